// File: doc/BRIEF.md
# SYSREF Phase Capture Detector

This block runs in the fast converter sample-clock domain and measures where the rising edge of a SYSREF alignment pulse falls within the period of a clock made by dividing that sample clock by four. A free-running 2-bit counter marks the four sample-clock slots of each divided period. Count 0 is the rising edge of the divided clock. SYSREF is resynchronised through a short flip-flop chain. The first 0-to-1 transition after arming is then converted into a slot number, with the fixed pipeline delay taken out of it.

The slot is reported as a 12-bit thermometer-style status word. The upper bits are always ones and the lowest bits are always zeros. A four-bit band in between shows the slot by how far the run of ones reaches down. A valid flag marks a captured result. The word and the flag stay frozen until a re-arm pulse clears both and opens the detector for the next edge. Software reads the word to judge whether SYSREF lands in a consistent slot from one power-up to the next.

Top module: `sysref_phase_detect`

## Requirements
- R1: After synchronous reset, and while nothing has been captured, `phase_word` reads 12'h000 and `phase_valid` reads 0.
- R2: The slot counter is cleared by reset and advances by one on every clock edge after reset. A SYSREF rising edge first seen high at the first clock edge after reset release, or any multiple of four edges later, is in slot 0 and reports 12'hFE0.
- R3: A SYSREF rising edge first sampled in slot 1 (one edge after a slot-0 edge) reports 12'hFC0.
- R4: A SYSREF rising edge first sampled in slot 2 reports 12'hF80.
- R5: A SYSREF rising edge first sampled in slot 3 reports 12'hF00.
- R6: Once `phase_valid` is 1, later SYSREF rising edges change neither `phase_word` nor `phase_valid`.
- R7: A `rearm` pulse sampled at a clock edge makes `phase_word` 12'h000 and `phase_valid` 0 after that edge. This holds even when a rising edge would have been captured at the same edge, and that edge is discarded.
- R8: When SYSREF is first sampled high at clock edge j, `phase_valid` and `phase_word` take their new values after edge j+2 and not earlier.
- R9: Only a 0-to-1 transition of the synchronised SYSREF is captured. A SYSREF level held high across a re-arm produces no capture until it falls and rises again.
- R10: Whenever `phase_valid` is 1, bits [11:8] are all 1, bits [4:0] are all 0, and bits [8:5] hold the ones of the thermometer band, which start at bit 8 and extend downward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast converter sample clock |
| rst | input | 1 | Synchronous active-high reset |
| sysref_in | input | 1 | SYSREF alignment pulse, asynchronous to the slot grid |
| rearm | input | 1 | Single-cycle pulse that clears the result and arms the detector |
| phase_word | output | 12 | Thermometer-style phase status word |
| phase_valid | output | 1 | High once a SYSREF rising edge has been captured |

## Verification
The assertions check on every cycle that the slot counter steps by one, that the edge pulse lasts a single cycle, and that a captured word keeps its fixed ones and zeros. They also check that a held result stays stable, that re-arm clears the result, and that the flag only rises right after an edge pulse. Only the bench scenarios can show that each of the four slots maps to its specific code, and that the capture lands exactly two edges after sampling. The bench also shows that a re-arm coinciding with a capture wins, and that a level held high across re-arm is not mistaken for a new edge.

// File: rtl/sysref_phase_pkg.sv
package sysref_phase_pkg;

  // Default geometry of the status word and the slot grid
  localparam int unsigned DEF_DIV_LOG2    = 2;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_WORD_W      = 12;
  localparam int unsigned DEF_THERM_LSB   = 5;

  // Slot in which SYSREF was first sampled high, given the counter value
  // seen at the capture edge and the sampling-to-capture latency.
  function automatic logic [31:0] slot_from_count(
    input logic [31:0] count_now,
    input int unsigned lat,
    input int unsigned div_log2
  );
    logic [31:0] mask;
    mask = (32'd1 << div_log2) - 32'd1;
    return (count_now - 32'(lat)) & mask;
  endfunction

endpackage

// File: rtl/sysref_div_counter.sv
module sysref_div_counter #(
  parameter int unsigned DIV_LOG2 = sysref_phase_pkg::DEF_DIV_LOG2
) (
  input  logic                clk,
  input  logic                rst,
  output logic [DIV_LOG2-1:0] slot_cnt
);

  always_ff @(posedge clk) begin
    if (rst) slot_cnt <= '0;
    else     slot_cnt <= slot_cnt + 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !rst |=> slot_cnt == DIV_LOG2'($past(slot_cnt) + 1'b1)); // R2

endmodule

// File: rtl/sysref_sync_edge.sv
module sysref_sync_edge #(
  parameter int unsigned SYNC_STAGES = sysref_phase_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);

  logic [SYNC_STAGES-1:0] chain;
  logic                   last_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[SYNC_STAGES-1];
  end

  assign rise = chain[SYNC_STAGES-1] & ~last_q;

  AST_RISE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R9

endmodule

// File: rtl/sysref_thermo_encode.sv
module sysref_thermo_encode #(
  parameter int unsigned DIV_LOG2  = sysref_phase_pkg::DEF_DIV_LOG2,
  parameter int unsigned WORD_W    = sysref_phase_pkg::DEF_WORD_W,
  parameter int unsigned THERM_LSB = sysref_phase_pkg::DEF_THERM_LSB
) (
  input  logic [DIV_LOG2-1:0] slot,
  output logic [WORD_W-1:0]   code
);

  logic [31:0] lowest_one;
  assign lowest_one = 32'(slot) + 32'(THERM_LSB);

  // A bit is one when it sits at or above the lowest one of the run
  genvar b;
  generate
    for (b = 0; b < WORD_W; b++) begin : g_bit
      assign code[b] = (32'(b) >= lowest_one);
    end
  endgenerate

endmodule

// File: rtl/sysref_capture.sv
module sysref_capture #(
  parameter int unsigned DIV_LOG2  = sysref_phase_pkg::DEF_DIV_LOG2,
  parameter int unsigned WORD_W    = sysref_phase_pkg::DEF_WORD_W,
  parameter int unsigned THERM_LSB = sysref_phase_pkg::DEF_THERM_LSB,
  parameter int unsigned PIPE_LAT  = sysref_phase_pkg::DEF_SYNC_STAGES
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rise,
  input  logic                rearm,
  input  logic [DIV_LOG2-1:0] slot_cnt,
  output logic [WORD_W-1:0]   word_q,
  output logic                valid_q
);

  localparam int unsigned NSLOT  = 1 << DIV_LOG2;
  localparam int unsigned HI_LSB = THERM_LSB + NSLOT - 1;

  logic [DIV_LOG2-1:0] slot;
  logic [WORD_W-1:0]   code;

  assign slot = DIV_LOG2'(sysref_phase_pkg::slot_from_count(32'(slot_cnt), PIPE_LAT, DIV_LOG2));

  sysref_thermo_encode #(
    .DIV_LOG2 (DIV_LOG2),
    .WORD_W   (WORD_W),
    .THERM_LSB(THERM_LSB)
  ) u_enc (
    .slot(slot),
    .code(code)
  );

  always_ff @(posedge clk) begin
    if (rst || rearm) begin
      valid_q <= 1'b0;
      word_q  <= '0;
    end else if (rise && !valid_q) begin
      valid_q <= 1'b1;
      word_q  <= code;
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !valid_q |-> word_q == '0); // R1
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    valid_q && !rearm |=> valid_q && $stable(word_q)); // R6
  AST_REARM_CLEAR: assert property (@(posedge clk) disable iff (rst)
    rearm |=> !valid_q && word_q == '0); // R7
  AST_SET_AFTER_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_q) |-> $past(rise)); // R8
  AST_WORD_FORM: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> (&word_q[WORD_W-1:HI_LSB]) && word_q[THERM_LSB-1:0] == '0); // R10

endmodule

// File: rtl/sysref_phase_detect.sv
module sysref_phase_detect #(
  parameter int unsigned DIV_LOG2    = sysref_phase_pkg::DEF_DIV_LOG2,
  parameter int unsigned SYNC_STAGES = sysref_phase_pkg::DEF_SYNC_STAGES,
  parameter int unsigned WORD_W      = sysref_phase_pkg::DEF_WORD_W,
  parameter int unsigned THERM_LSB   = sysref_phase_pkg::DEF_THERM_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sysref_in,
  input  logic              rearm,
  output logic [WORD_W-1:0] phase_word,
  output logic              phase_valid
);

  logic [DIV_LOG2-1:0] slot_cnt;
  logic                rise;

  sysref_div_counter #(.DIV_LOG2(DIV_LOG2)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .slot_cnt(slot_cnt)
  );

  sysref_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (sysref_in),
    .rise(rise)
  );

  sysref_capture #(
    .DIV_LOG2 (DIV_LOG2),
    .WORD_W   (WORD_W),
    .THERM_LSB(THERM_LSB),
    .PIPE_LAT (SYNC_STAGES)
  ) u_cap (
    .clk     (clk),
    .rst     (rst),
    .rise    (rise),
    .rearm   (rearm),
    .slot_cnt(slot_cnt),
    .word_q  (phase_word),
    .valid_q (phase_valid)
  );

endmodule

// File: tb/sim_sysref_phase_detect.sv
module sim_sysref_phase_detect;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sysref_in = 1'b0;
  logic        rearm = 1'b0;
  logic [11:0] phase_word;
  logic        phase_valid;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sysref_phase_detect u0 (
    .clk        (clk),
    .rst        (rst),
    .sysref_in  (sysref_in),
    .rearm      (rearm),
    .phase_word (phase_word),
    .phase_valid(phase_valid)
  );

  // Slot model from R2: cleared by reset, +1 per edge afterwards.
  // At a falling edge it holds the slot of the next rising edge.
  logic [1:0] bslot;
  always_ff @(posedge clk) begin
    if (rst) bslot <= 2'd0;
    else     bslot <= bslot + 2'd1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_slot(input int s);
    @(negedge clk);
    while (int'(bslot) != s) @(negedge clk);
  endtask

  task automatic do_rearm(input string req);
    @(negedge clk); rearm = 1'b1;
    @(negedge clk); rearm = 1'b0;
    chk({req, " rearm valid"}, 32'(phase_valid), 32'd0);
    chk({req, " rearm word"}, 32'(phase_word), 32'h000);
  endtask

  // One-cycle pulse sampled in slot s, checks latency, code and form
  task automatic t_slot(input int s, input logic [11:0] exp, input string req);
    do_rearm("R7");
    repeat (4) @(negedge clk);
    wait_slot(s);
    sysref_in = 1'b1;
    @(negedge clk); sysref_in = 1'b0;
    @(negedge clk);
    chk("R8 not yet valid", 32'(phase_valid), 32'd0);
    @(negedge clk);
    chk("R8 valid after edge j+2", 32'(phase_valid), 32'd1);
    chk(req, 32'(phase_word), 32'(exp));
    chk("R10 fixed bits", 32'({phase_word[11:8], phase_word[4:0]}), 32'h1E0);
  endtask

  task automatic t_reset(input string req);
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    chk({req, " word"}, 32'(phase_word), 32'h000);
    chk({req, " valid"}, 32'(phase_valid), 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_first_only();
    t_slot(1, 12'hFC0, "R3 slot1 code");
    wait_slot(3);
    sysref_in = 1'b1;
    @(negedge clk); sysref_in = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 word held", 32'(phase_word), 32'hFC0);
    chk("R6 valid held", 32'(phase_valid), 32'd1);
  endtask

  task automatic t_rearm_wins();
    do_rearm("R7");
    repeat (4) @(negedge clk);
    wait_slot(0);
    sysref_in = 1'b1;
    @(negedge clk); sysref_in = 1'b0;
    @(negedge clk); rearm = 1'b1;
    @(negedge clk); rearm = 1'b0;
    chk("R7 coincident valid", 32'(phase_valid), 32'd0);
    chk("R7 coincident word", 32'(phase_word), 32'h000);
    repeat (4) @(negedge clk);
    chk("R7 edge discarded", 32'(phase_valid), 32'd0);
  endtask

  task automatic t_level_high();
    @(negedge clk); sysref_in = 1'b1;
    repeat (5) @(negedge clk);
    do_rearm("R9");
    repeat (8) @(negedge clk);
    chk("R9 held level no capture", 32'(phase_valid), 32'd0);
    chk("R9 held level word", 32'(phase_word), 32'h000);
    sysref_in = 1'b0;
    repeat (4) @(negedge clk);
    wait_slot(2);
    sysref_in = 1'b1;
    @(negedge clk); sysref_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R9 new edge captured", 32'(phase_valid), 32'd1);
    chk("R4 slot2 code after level", 32'(phase_word), 32'hF80);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset word", 32'(phase_word), 32'h000);
    chk("R1 reset valid", 32'(phase_valid), 32'd0);
    rst = 1'b0;
    t_slot(0, 12'hFE0, "R2 slot0 code");
    t_slot(1, 12'hFC0, "R3 slot1 code");
    t_slot(2, 12'hF80, "R4 slot2 code");
    t_slot(3, 12'hF00, "R5 slot3 code");
    t_first_only();
    t_rearm_wins();
    t_level_high();
    t_reset("R1 mid-run reset");
    t_slot(2, 12'hF80, "R4 slot2 after reset");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule